// File: doc/BRIEF.md
# Breakpoint Tagging and Acknowledge Unit

This unit watches an external breakpoint request together with the kind of bus cycle running at that moment. It decides which instruction the breakpoint belongs to. There are two cases:

- **Prefetch.** If the request lands on an instruction prefetch, the fetched word gets a tag bit. The bit follows that word through the pipeline stage registers. The breakpoint is acknowledged when the word completes in the final stage.
- **Operand access.** If the request lands on an operand read or write, a pending flag is set. The breakpoint is acknowledged when the current instruction completes.

An acknowledged breakpoint does one of two things. If debug is enabled, it puts the core into debug mode, which holds until an explicit exit. Otherwise it issues a one-cycle exception request. While debug mode is active, the pipeline tracking enable is withdrawn.

Top module: `bkpt_tag_unit`

## Requirements
- R1: During and right after synchronous reset, `bkpt_ack`, `dbg_mode` and `exc_req` are 0 and `trace_en` is 1.
- R2: A request during a prefetch (`bus_kind`=1) tags the fetched word. The word enters stage 0 on the next `pipe_adv` and moves one stage per `pipe_adv`. After STAGES advances it sits in the last stage. An `insn_done` in that state gives `bkpt_ack`=1 in the following cycle.
- R3: A later prefetch without a request replaces the held word, and its tag is then 0. An `insn_done` on an untagged last stage gives no acknowledge. An `insn_done` without `pipe_adv` empties the last stage's tag.
- R4: A request during an operand read (`bus_kind`=2) or operand write (`bus_kind`=3) is acknowledged on the next `insn_done`. This includes an `insn_done` in the same cycle. The acknowledge appears one cycle later.
- R5: A request with `bus_kind`=0 (idle) has no effect.
- R6: `pipe_flush` clears every tag bit, including the held prefetch word. It leaves a pending operand breakpoint in place.
- R7: `bkpt_ack` is high for one cycle per completing instruction. A tagged completion and a pending operand breakpoint in the same cycle yield a single acknowledge.
- R8: With `dbg_en`=1 at the acknowledged completion, `dbg_mode` rises in the same cycle as `bkpt_ack` and `exc_req` stays 0. With `dbg_en`=0, `exc_req` pulses with `bkpt_ack` and `dbg_mode` is unchanged.
- R9: `dbg_mode` stays 1 until a cycle with `dbg_exit`=1, and falls on the next edge. `trace_en` is 0 exactly while `dbg_mode` is 1.
- R10: While `dbg_mode` is 1, `insn_done` is ignored: there is no acknowledge, and tags and the pending flag are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bkpt_req | input | 1 | External breakpoint request |
| bus_kind | input | 2 | Bus cycle kind: 0 idle, 1 prefetch, 2 operand read, 3 operand write |
| pipe_adv | input | 1 | Pipeline advance strobe |
| insn_done | input | 1 | Instruction in last stage completes |
| pipe_flush | input | 1 | Pipeline flush |
| dbg_en | input | 1 | Debug mode enable |
| dbg_exit | input | 1 | Leave debug mode |
| bkpt_ack | output | 1 | Breakpoint acknowledge pulse |
| dbg_mode | output | 1 | Debug mode active |
| exc_req | output | 1 | Breakpoint exception request pulse |
| trace_en | output | 1 | Pipeline tracking enable |

## Verification
A lost or misplaced tag bit shows up as an acknowledge that is missing, early or late. This is visible one cycle after the completion strobe that should have matched the tagged word. Since the tag must pass through every stage first, the effect appears only after STAGES advances. A stuck pending flag shows as extra acknowledges on every later completion. A wrong debug state shows at once on `trace_en` and `exc_req`. The bench compares all four outputs on every cycle against a behavioural queue model. Directed sequences target each case.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE     = 2'd0,
    BUS_PREFETCH = 2'd1,
    BUS_OPRD     = 2'd2,
    BUS_OPWR     = 2'd3
  } bus_kind_e;
endpackage

// File: rtl/bkpt_tag_pipe.sv
module bkpt_tag_pipe #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              adv,
  input  logic              pf_cycle,
  input  logic              pf_tag,
  input  logic              retire,
  output logic [STAGES-1:0] tags,
  output logic              tail_tag
);
  localparam int LAST = STAGES - 1;

  logic fetch_tag;

  // Tag of the most recently prefetched word, waiting to enter stage 0
  always_ff @(posedge clk) begin
    if (rst || flush)   fetch_tag <= 1'b0;
    else if (pf_cycle)  fetch_tag <= pf_tag;
    else if (adv)       fetch_tag <= 1'b0;
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      assign feed = fetch_tag;
    end else begin : g_body
      assign feed = tags[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst || flush)                       tags[i] <= 1'b0;
      else if (adv)                           tags[i] <= feed;
      else if ((i == LAST) && retire)         tags[i] <= 1'b0;
    end
  end

  assign tail_tag = tags[LAST];
endmodule

// File: rtl/bkpt_opnd_pend.sv
module bkpt_opnd_pend (
  input  logic clk,
  input  logic rst,
  input  logic op_hit,
  input  logic retire,
  output logic pend
);
  // Flush deliberately has no effect here: the operand breakpoint belongs
  // to the instruction in execution, not to a fetched word.
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (retire)  pend <= 1'b0;
    else if (op_hit)  pend <= 1'b1;
  end
endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic insn_done,
  input  logic tail_tag,
  input  logic pend,
  input  logic op_hit,
  input  logic dbg_en,
  input  logic dbg_exit,
  output logic retire,
  output logic bkpt_ack,
  output logic exc_req,
  output logic dbg_mode,
  output logic trace_en
);
  logic fire;
  logic dbg_nxt;

  assign retire  = insn_done && !dbg_mode;
  assign fire    = retire && (tail_tag || pend || op_hit);
  assign dbg_nxt = dbg_mode ? !dbg_exit : (fire && dbg_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      bkpt_ack <= 1'b0;
      exc_req  <= 1'b0;
      dbg_mode <= 1'b0;
      trace_en <= 1'b1;
    end else begin
      bkpt_ack <= fire;
      exc_req  <= fire && !dbg_en;
      dbg_mode <= dbg_nxt;
      trace_en <= !dbg_nxt;
    end
  end
endmodule

// File: rtl/bkpt_tag_unit.sv
module bkpt_tag_unit #(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bkpt_req,
  input  logic [1:0] bus_kind,
  input  logic       pipe_adv,
  input  logic       insn_done,
  input  logic       pipe_flush,
  input  logic       dbg_en,
  input  logic       dbg_exit,
  output logic       bkpt_ack,
  output logic       dbg_mode,
  output logic       exc_req,
  output logic       trace_en
);
  import bkpt_pkg::*;

  logic              pf_cycle;
  logic              op_hit;
  logic              retire;
  logic              tail_tag;
  logic              pend;
  logic [STAGES-1:0] stage_tags;

  assign pf_cycle = (bus_kind == BUS_PREFETCH);
  assign op_hit   = bkpt_req && ((bus_kind == BUS_OPRD) || (bus_kind == BUS_OPWR));

  bkpt_tag_pipe #(.STAGES(STAGES)) pipe_i (
    .clk      (clk),
    .rst      (rst),
    .flush    (pipe_flush),
    .adv      (pipe_adv),
    .pf_cycle (pf_cycle),
    .pf_tag   (bkpt_req),
    .retire   (retire),
    .tags     (stage_tags),
    .tail_tag (tail_tag)
  );

  bkpt_opnd_pend pend_i (
    .clk    (clk),
    .rst    (rst),
    .op_hit (op_hit),
    .retire (retire),
    .pend   (pend)
  );

  bkpt_ack_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .tail_tag  (tail_tag),
    .pend      (pend),
    .op_hit    (op_hit),
    .dbg_en    (dbg_en),
    .dbg_exit  (dbg_exit),
    .retire    (retire),
    .bkpt_ack  (bkpt_ack),
    .exc_req   (exc_req),
    .dbg_mode  (dbg_mode),
    .trace_en  (trace_en)
  );
endmodule

// File: rtl/bkpt_tag_unit_chk.sv
module bkpt_tag_unit_chk #(
  parameter int STAGES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_done,
  input logic              pipe_flush,
  input logic              dbg_en,
  input logic              dbg_exit,
  input logic              bkpt_ack,
  input logic              dbg_mode,
  input logic              exc_req,
  input logic              trace_en,
  input logic [STAGES-1:0] stage_tags
);
  // R4 / R7: an acknowledge always follows a completion strobe
  assert_ack_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    bkpt_ack |-> $past(insn_done));

  // R8: exception request only with acknowledge and outside debug mode
  assert_exc_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (bkpt_ack && !dbg_mode));

  // R8: debug entry only through an acknowledge with debug enabled
  assert_dbg_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_mode) |-> (bkpt_ack && $past(dbg_en)));

  // R9: debug mode holds until exit
  assert_dbg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && !dbg_exit) |=> dbg_mode);

  // R9: tracking withdrawn during debug mode
  assert_trace_off_R9: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |-> !trace_en);

  // R10: no acknowledge caused from inside debug mode
  assert_no_ack_in_dbg_R10: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |=> !bkpt_ack);

  // R6: flush empties every stage tag
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
    pipe_flush |=> (stage_tags == '0));
endmodule

bind bkpt_tag_unit bkpt_tag_unit_chk #(.STAGES(STAGES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .insn_done  (insn_done),
  .pipe_flush (pipe_flush),
  .dbg_en     (dbg_en),
  .dbg_exit   (dbg_exit),
  .bkpt_ack   (bkpt_ack),
  .dbg_mode   (dbg_mode),
  .exc_req    (exc_req),
  .trace_en   (trace_en),
  .stage_tags (stage_tags)
);

// File: tb/bkpt_tag_unit_tb_top.sv
module bkpt_tag_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 3;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bkpt_req = 1'b0;
  logic [1:0] bus_kind = 2'd0;
  logic       pipe_adv = 1'b0;
  logic       insn_done = 1'b0;
  logic       pipe_flush = 1'b0;
  logic       dbg_en = 1'b0;
  logic       dbg_exit = 1'b0;
  logic       bkpt_ack, dbg_mode, exc_req, trace_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_tag_unit #(.STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .bkpt_req(bkpt_req), .bus_kind(bus_kind),
    .pipe_adv(pipe_adv), .insn_done(insn_done), .pipe_flush(pipe_flush),
    .dbg_en(dbg_en), .dbg_exit(dbg_exit), .bkpt_ack(bkpt_ack),
    .dbg_mode(dbg_mode), .exc_req(exc_req), .trace_en(trace_en)
  );

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  // Behavioural reference state
  bit m_fetch;
  bit m_q[$];
  bit m_pend, m_dbg, m_ack, m_exc, m_tr;

  function automatic void model_reset();
    m_fetch = 0; m_pend = 0; m_dbg = 0; m_ack = 0; m_exc = 0; m_tr = 1;
    m_q.delete();
    for (int i = 0; i < STAGES; i++) m_q.push_back(1'b0);
  endfunction

  function automatic void model_step(bit req, bit [1:0] kind, bit adv, bit dn,
                                     bit fl, bit en, bit ex);
    bit eff, op, fire, old_fetch;
    eff  = dn && !m_dbg;
    op   = req && (kind == 2'd2 || kind == 2'd3);
    fire = eff && (m_q[STAGES-1] || m_pend || op);
    old_fetch = m_fetch;
    if (fl) begin
      m_fetch = 0;
      foreach (m_q[i]) m_q[i] = 0;
    end else begin
      if (adv) begin
        m_q.push_front(old_fetch);
        void'(m_q.pop_back());
      end else if (eff) begin
        m_q[STAGES-1] = 0;
      end
      if (kind == 2'd1) m_fetch = req;
      else if (adv)     m_fetch = 0;
    end
    if (eff)     m_pend = 0;
    else if (op) m_pend = 1;
    m_dbg = m_dbg ? !ex : (fire && en);
    m_ack = fire;
    m_exc = fire && !en;
    m_tr  = !m_dbg;
  endfunction

  task automatic check(string req_tag, bit cond, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  task automatic compare(string req_tag);
    check(req_tag, bkpt_ack == m_ack, "bkpt_ack", bkpt_ack, m_ack);
    check(req_tag, dbg_mode == m_dbg, "dbg_mode", dbg_mode, m_dbg);
    check(req_tag, exc_req  == m_exc, "exc_req",  exc_req,  m_exc);
    check(req_tag, trace_en == m_tr,  "trace_en", trace_en, m_tr);
  endtask

  // One clock: drive at negedge, update model, sample at next negedge
  task automatic step(string req_tag, bit req, bit [1:0] kind, bit adv, bit dn,
                      bit fl, bit en, bit ex);
    bkpt_req = req; bus_kind = kind; pipe_adv = adv; insn_done = dn;
    pipe_flush = fl; dbg_en = en; dbg_exit = ex;
    model_step(req, kind, adv, dn, fl, en, ex);
    @(posedge clk);
    @(negedge clk);
    compare(req_tag);
  endtask

  task automatic idle(string req_tag, int n);
    for (int i = 0; i < n; i++) step(req_tag, 0, 2'd0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bkpt_req = 0; bus_kind = 0; pipe_adv = 0; insn_done = 0;
    pipe_flush = 0; dbg_en = 0; dbg_exit = 0;
    model_reset();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    idle("R1", 2);
    check("R1", bkpt_ack == 0 && trace_en == 1, "reset outputs", bkpt_ack, 0);

    // R2: tagged prefetch, three advances, completion
    step("R2", 1, 2'd1, 0, 0, 0, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R2", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R2", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R2", bkpt_ack == 1 && exc_req == 1, "ack after tagged completion", bkpt_ack, 1);
    idle("R2", 1);
    check("R7", bkpt_ack == 0, "ack single pulse", bkpt_ack, 0);

    // R3: tagged prefetch overwritten by untagged prefetch
    step("R3", 1, 2'd1, 0, 0, 0, 0, 0);
    step("R3", 0, 2'd1, 0, 0, 0, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R3", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R3", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R3", bkpt_ack == 0, "no ack for overwritten tag", bkpt_ack, 0);
    // R3: completion without advance empties the last stage
    step("R3", 1, 2'd1, 0, 0, 0, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R3", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R3", 0, 2'd0, 0, 1, 0, 0, 0);
    step("R3", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R3", bkpt_ack == 0, "second completion untagged", bkpt_ack, 0);

    // R4: operand read pending, then completion
    step("R4", 1, 2'd2, 0, 0, 0, 0, 0);
    idle("R4", 2);
    check("R4", bkpt_ack == 0, "no ack before completion", bkpt_ack, 0);
    step("R4", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R4", bkpt_ack == 1, "ack at end of instruction", bkpt_ack, 1);
    // R4: operand write in the completing cycle
    step("R4", 1, 2'd3, 0, 1, 0, 0, 0);
    check("R4", bkpt_ack == 1, "same-cycle operand ack", bkpt_ack, 1);
    step("R4", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R4", bkpt_ack == 0, "pending consumed", bkpt_ack, 0);

    // R5: idle-cycle request ignored
    step("R5", 1, 2'd0, 0, 0, 0, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R5", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R5", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R5", bkpt_ack == 0, "idle request ignored", bkpt_ack, 0);

    // R6: flush clears tags, keeps operand pending
    step("R6", 1, 2'd1, 0, 0, 0, 0, 0);
    step("R6", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R6", 1, 2'd2, 0, 0, 0, 0, 0);
    step("R6", 0, 2'd0, 0, 0, 1, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R6", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R6", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R6", bkpt_ack == 1, "pending survives flush", bkpt_ack, 1);
    step("R6", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R6", bkpt_ack == 0, "tag removed by flush", bkpt_ack, 0);

    // R7: tagged completion coincides with pending operand breakpoint
    step("R7", 1, 2'd1, 0, 0, 0, 0, 0);
    for (int i = 0; i < STAGES; i++) step("R7", 0, 2'd0, 1, 0, 0, 0, 0);
    step("R7", 1, 2'd2, 0, 0, 0, 0, 0);
    step("R7", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R7", bkpt_ack == 1, "one ack for both", bkpt_ack, 1);
    step("R7", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R7", bkpt_ack == 0, "no second ack", bkpt_ack, 0);

    // R8 / R9 / R10: debug entry, hold, ignored completion, exit
    step("R8", 1, 2'd2, 0, 0, 0, 1, 0);
    step("R8", 0, 2'd0, 0, 1, 0, 1, 0);
    check("R8", dbg_mode == 1 && exc_req == 0, "debug entry", dbg_mode, 1);
    step("R10", 1, 2'd2, 0, 0, 0, 1, 0);
    step("R10", 0, 2'd0, 0, 1, 0, 1, 0);
    check("R10", bkpt_ack == 0, "completion ignored in debug", bkpt_ack, 0);
    idle("R9", 3);
    check("R9", dbg_mode == 1 && trace_en == 0, "debug held", dbg_mode, 1);
    step("R9", 0, 2'd0, 0, 0, 0, 0, 1);
    check("R9", dbg_mode == 0 && trace_en == 1, "debug exit", dbg_mode, 0);
    step("R10", 0, 2'd0, 0, 1, 0, 0, 0);
    check("R10", bkpt_ack == 1 && exc_req == 1, "pending kept through debug", bkpt_ack, 1);

    // Mixed traffic compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] r;
      r = 8'($urandom);
      step("R7", r[0], 2'(r[2:1]), r[3], r[4] & r[5], (r[7:6] == 2'b11) && r[3],
           r[6], r[7] & r[5]);
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule